// File: doc/BRIEF.md
# Serial Link Flow Control Unit

This block manages the link layer of an asynchronous serial port. It sits between the receive path, the receive FIFO, the transmit byte path and the modem control lines. It decides which received characters are stored, and which transmit slots carry a byte. It also decides when the far end is asked to pause or resume. Character framing, baud timing and the FIFOs themselves are outside it.

Software controls the block through one 32-bit control word. A write supplies an AND mask and an XOR mask, and the block returns the word as it was before the write. Bits 16 to 20 are live status owned by the hardware:

- received-XOFF stop
- requested remote pause
- carrier lost
- data set not ready
- ring

The unit offers two flow-control styles:

- **In-band XON/XOFF.** The block consumes incoming pause and resume bytes, and places its own pause or resume byte ahead of data.
- **Hardware handshake.** RTS is raised (driven inactive) when the receive FIFO runs short of space.

Top module: `serial_flow_ctrl`

## Requirements
- R1: A write with `wr_en` sets the software bits to `(word AND and_mask) XOR xor_mask`. In the next cycle `ctl_prev` shows the full word as it was before the write, including the status bits.
- R2: Bits 4..15 and 21..31 hold whatever software writes and read back unchanged. Bits 16..20 cannot be changed by the masks.
- R3: Bit 18 mirrors `dcd_n`, bit 19 mirrors `dsr_n` and bit 20 mirrors `ri`, one cycle after the pin changes.
- R4: With bit 1 clear, a rising edge on `dcd_n` gives a one-cycle `rx_evt`. A character received while `dcd_n` is high also gives a one-cycle `rx_evt` and is not written to the FIFO. With bit 1 set, neither case raises an event, and the character is stored.
- R5: With bit 0 set (in-band mode), a received 0x13 sets bit 16 and a received 0x11 clears it. Neither byte is stored. With bit 0 clear, bit 16 reads 0 and both bytes are stored as data.
- R6: While bit 16 is set, no data byte is sent.
- R7: The FIFO counts as nearly full when `fifo_free < free_thresh`. The block samples this in a cycle that stores a character (it may then set the hold state) or pulses `fifo_rd` (it may then clear the hold state). In in-band mode bit 17 shows the hold state, and `rts_n` stays 0. Otherwise `rts_n` shows the hold state, and bit 17 reads 0.
- R8: In in-band mode each change of the hold state queues one control byte: 0x13 on entering hold, 0x11 on leaving it. That byte takes the next usable transmit slot ahead of any data, and it is sent once.
- R9: While `cts_n` is high, a transmit slot carries nothing.
- R10: With bit 2 clear, a transmit slot carries nothing while `dsr_n` is high. With bit 2 set, `dsr_n` does not gate transmission.
- R11: Bit 3 set drives `dtr_n` high. In that state no transmit slot carries a byte and no received character is stored.
- R12: After reset the following are all 0: the control word, `ctl_prev`, `dtr_n`, `rts_n`, `rx_evt`, `fifo_wr`, `tx_out_valid` and `tx_pop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Apply mask update this cycle |
| and_mask | input | 32 | AND mask for the update |
| xor_mask | input | 32 | XOR mask for the update |
| ctl_word | output | 32 | Current control and status word |
| ctl_prev | output | 32 | Word value before the latest update |
| rx_valid | input | 1 | Received character strobe |
| rx_byte | input | 8 | Received character |
| fifo_wr | output | 1 | Write strobe to receive FIFO |
| fifo_wdata | output | 8 | Character for receive FIFO |
| fifo_rd | input | 1 | Receive FIFO was read this cycle |
| fifo_free | input | CNT_W | Free entries in receive FIFO |
| free_thresh | input | CNT_W | Nearly-full free-space threshold |
| tx_valid | input | 1 | A data byte is waiting to be sent |
| tx_byte | input | 8 | Waiting data byte |
| tx_pop | output | 1 | Waiting data byte was consumed |
| tx_slot | input | 1 | Transmitter can accept a byte now |
| tx_out_valid | output | 1 | Byte handed to transmitter |
| tx_out_byte | output | 8 | Byte handed to transmitter |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| ri | input | 1 | Ring indicator |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| rx_evt | output | 1 | Carrier event pulse |

## Verification
Every result of the block appears one clock edge after the stimulus that causes it. This covers the updated word and previous value, FIFO writes, events, transmit outputs, RTS and the status mirrors. The bench changes inputs on the falling edge and checks on the next falling edge, so exactly one rising edge lies between them. A strobe is dropped at the same falling edge where its result is checked. Control-byte injection is checked on the first slot after the change in hold state, and then again on the following slot to confirm it is not repeated.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int WORD_W      = 32;
  localparam int B_SWFLOW    = 0;
  localparam int B_DCD_IGN   = 1;
  localparam int B_DSR_IGN   = 2;
  localparam int B_DTR_OFF   = 3;
  localparam int B_XOFF_RX   = 16;
  localparam int HW_BITS     = 5;
  localparam logic [7:0] XON_CHAR  = 8'h11;
  localparam logic [7:0] XOFF_CHAR = 8'h13;
  localparam logic [WORD_W-1:0] HW_MASK =
    WORD_W'(((1 << HW_BITS) - 1) << B_XOFF_RX);

  typedef enum logic [1:0] {
    RX_STORE = 2'd0,
    RX_DROP  = 2'd1,
    RX_CTRL  = 2'd2,
    RX_OFF   = 2'd3
  } rx_class_e;
endpackage

// File: rtl/sfc_state_reg.sv
module sfc_state_reg
  import sfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] and_mask,
  input  logic [WORD_W-1:0] xor_mask,
  input  logic [HW_BITS-1:0] hw_bits,
  output logic [WORD_W-1:0] sw_q,
  output logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] prev_q
);
  logic [WORD_W-1:0] upd;

  assign word = sw_q | (WORD_W'(hw_bits) << B_XOFF_RX);
  assign upd  = ((word & and_mask) ^ xor_mask) & ~HW_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q   <= '0;
      prev_q <= '0;
    end else if (wr_en) begin
      sw_q   <= upd;
      prev_q <= word;
    end
  end
endmodule

// File: rtl/sfc_rx_filter.sv
module sfc_rx_filter
  import sfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       sw_flow,
  input  logic       dcd_ign,
  input  logic       dtr_off,
  input  logic       dcd_n,
  input  logic       dsr_n,
  input  logic       ri,
  output logic       fifo_wr,
  output logic [7:0] fifo_wdata,
  output logic       rx_evt,
  output logic       xoff_rx,
  output logic       dcd_q,
  output logic       dsr_q,
  output logic       ri_q,
  output logic       store_now
);
  rx_class_e cls;
  logic      is_ctrl;
  logic      carrier_rise;

  assign is_ctrl      = (rx_byte == XON_CHAR) || (rx_byte == XOFF_CHAR);
  assign carrier_rise = dcd_n & ~dcd_q;

  always_comb begin
    if (dtr_off)                cls = RX_OFF;
    else if (!dcd_ign && dcd_n) cls = RX_DROP;
    else if (sw_flow && is_ctrl) cls = RX_CTRL;
    else                        cls = RX_STORE;
  end

  assign store_now = rx_valid && (cls == RX_STORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      dcd_q      <= 1'b0;
      dsr_q      <= 1'b0;
      ri_q       <= 1'b0;
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
      rx_evt     <= 1'b0;
      xoff_rx    <= 1'b0;
    end else begin
      dcd_q   <= dcd_n;
      dsr_q   <= dsr_n;
      ri_q    <= ri;
      fifo_wr <= store_now;
      if (store_now) fifo_wdata <= rx_byte;
      rx_evt  <= !dcd_ign && (carrier_rise || (rx_valid && cls == RX_DROP));
      if (!sw_flow)
        xoff_rx <= 1'b0;
      else if (rx_valid && cls == RX_CTRL)
        xoff_rx <= (rx_byte == XOFF_CHAR);
    end
  end
endmodule

// File: rtl/sfc_flow_hold.sv
module sfc_flow_hold #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_flow,
  input  logic             store_now,
  input  logic             fifo_rd,
  input  logic [CNT_W-1:0] fifo_free,
  input  logic [CNT_W-1:0] free_thresh,
  input  logic             take,
  output logic             hold_q,
  output logic             pend_q
);
  logic near;
  logic hold_d;

  assign near = fifo_free < free_thresh;

  always_comb begin
    hold_d = hold_q;
    if (store_now && near)      hold_d = 1'b1;
    else if (fifo_rd && !near)  hold_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      if (!sw_flow)              pend_q <= 1'b0;
      else if (hold_d != hold_q) pend_q <= 1'b1;
      else if (take)             pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sfc_tx_arb.sv
module sfc_tx_arb
  import sfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_slot,
  input  logic       tx_valid,
  input  logic [7:0] tx_byte,
  input  logic       pend,
  input  logic       hold,
  input  logic       xoff_stop,
  input  logic       cts_n,
  input  logic       dsr_q,
  input  logic       dsr_ign,
  input  logic       dtr_off,
  output logic       take,
  output logic       tx_pop,
  output logic       tx_out_valid,
  output logic [7:0] tx_out_byte
);
  logic line_ok;
  logic send_data;

  assign line_ok   = tx_slot && !cts_n && !dtr_off && (dsr_ign || !dsr_q);
  assign take      = line_ok && pend;
  assign send_data = line_ok && !pend && tx_valid && !xoff_stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pop       <= 1'b0;
      tx_out_valid <= 1'b0;
      tx_out_byte  <= '0;
    end else begin
      tx_pop       <= send_data;
      tx_out_valid <= take || send_data;
      if (take)           tx_out_byte <= hold ? XOFF_CHAR : XON_CHAR;
      else if (send_data) tx_out_byte <= tx_byte;
    end
  end
endmodule

// File: rtl/serial_flow_ctrl.sv
module serial_flow_ctrl
  import sfc_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] and_mask,
  input  logic [WORD_W-1:0] xor_mask,
  output logic [WORD_W-1:0] ctl_word,
  output logic [WORD_W-1:0] ctl_prev,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              fifo_wr,
  output logic [7:0]        fifo_wdata,
  input  logic              fifo_rd,
  input  logic [CNT_W-1:0]  fifo_free,
  input  logic [CNT_W-1:0]  free_thresh,
  input  logic              tx_valid,
  input  logic [7:0]        tx_byte,
  output logic              tx_pop,
  input  logic              tx_slot,
  output logic              tx_out_valid,
  output logic [7:0]        tx_out_byte,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              dcd_n,
  input  logic              ri,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              rx_evt
);
  logic [WORD_W-1:0]  sw_q;
  logic [HW_BITS-1:0] hw_bits;
  logic sw_flow, xoff_rx, dcd_q, dsr_q, ri_q, store_now;
  logic hold_q, pend_q, take, xoff_stop, hold_vis;

  assign sw_flow   = sw_q[B_SWFLOW];
  assign xoff_stop = xoff_rx & sw_flow;
  assign hold_vis  = hold_q & sw_flow;
  assign hw_bits   = {ri_q, dsr_q, dcd_q, hold_vis, xoff_stop};
  assign dtr_n     = sw_q[B_DTR_OFF];
  assign rts_n     = hold_q & ~sw_flow;

  sfc_state_reg u_state (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .and_mask (and_mask),
    .xor_mask (xor_mask),
    .hw_bits  (hw_bits),
    .sw_q     (sw_q),
    .word     (ctl_word),
    .prev_q   (ctl_prev)
  );

  sfc_rx_filter u_rx (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .sw_flow    (sw_flow),
    .dcd_ign    (sw_q[B_DCD_IGN]),
    .dtr_off    (sw_q[B_DTR_OFF]),
    .dcd_n      (dcd_n),
    .dsr_n      (dsr_n),
    .ri         (ri),
    .fifo_wr    (fifo_wr),
    .fifo_wdata (fifo_wdata),
    .rx_evt     (rx_evt),
    .xoff_rx    (xoff_rx),
    .dcd_q      (dcd_q),
    .dsr_q      (dsr_q),
    .ri_q       (ri_q),
    .store_now  (store_now)
  );

  sfc_flow_hold #(.CNT_W(CNT_W)) u_hold (
    .clk         (clk),
    .rst         (rst),
    .sw_flow     (sw_flow),
    .store_now   (store_now),
    .fifo_rd     (fifo_rd),
    .fifo_free   (fifo_free),
    .free_thresh (free_thresh),
    .take        (take),
    .hold_q      (hold_q),
    .pend_q      (pend_q)
  );

  sfc_tx_arb u_tx (
    .clk          (clk),
    .rst          (rst),
    .tx_slot      (tx_slot),
    .tx_valid     (tx_valid),
    .tx_byte      (tx_byte),
    .pend         (pend_q),
    .hold         (hold_q),
    .xoff_stop    (xoff_stop),
    .cts_n        (cts_n),
    .dsr_q        (dsr_q),
    .dsr_ign      (sw_q[B_DSR_IGN]),
    .dtr_off      (sw_q[B_DTR_OFF]),
    .take         (take),
    .tx_pop       (tx_pop),
    .tx_out_valid (tx_out_valid),
    .tx_out_byte  (tx_out_byte)
  );
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [31:0] and_mask,
  input logic [31:0] xor_mask,
  input logic [31:0] ctl_word,
  input logic [31:0] ctl_prev,
  input logic        rx_valid,
  input logic        fifo_wr,
  input logic        tx_slot,
  input logic        tx_pop,
  input logic        tx_out_valid,
  input logic        cts_n,
  input logic        dcd_n,
  input logic        dtr_n,
  input logic        rts_n,
  input logic        rx_evt
);
  logic [31:0] nxt_w;
  assign nxt_w = (ctl_word & and_mask) ^ xor_mask;

  a_r1_prev_value: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ctl_prev == $past(ctl_word)));

  a_r11_dtr_pin: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (dtr_n == $past(nxt_w[3])));

  a_r11_dtr_no_store: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && ctl_word[3]) |=> !fifo_wr);

  a_r9_cts_blocks: assert property (@(posedge clk) disable iff (rst)
    (tx_slot && cts_n) |=> !tx_out_valid);

  a_r4_carrier_drop: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !ctl_word[1] && !ctl_word[3] && dcd_n) |=> (rx_evt && !fifo_wr));

  a_r5_mode_off_clear: assert property (@(posedge clk) disable iff (rst)
    !ctl_word[0] |-> (!ctl_word[16] && !ctl_word[17]));

  a_r7_rts_inband: assert property (@(posedge clk) disable iff (rst)
    ctl_word[0] |-> !rts_n);

  a_r6_xoff_no_data: assert property (@(posedge clk) disable iff (rst)
    (tx_slot && ctl_word[16]) |=> !tx_pop);

  a_r8_pop_has_byte: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> tx_out_valid);
endmodule

bind serial_flow_ctrl sfc_checker u_sfc_checker (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .and_mask     (and_mask),
  .xor_mask     (xor_mask),
  .ctl_word     (ctl_word),
  .ctl_prev     (ctl_prev),
  .rx_valid     (rx_valid),
  .fifo_wr      (fifo_wr),
  .tx_slot      (tx_slot),
  .tx_pop       (tx_pop),
  .tx_out_valid (tx_out_valid),
  .cts_n        (cts_n),
  .dcd_n        (dcd_n),
  .dtr_n        (dtr_n),
  .rts_n        (rts_n),
  .rx_evt       (rx_evt)
);

// File: tb/serial_flow_ctrl_bench.sv
module serial_flow_ctrl_bench;
  localparam int CNT_W = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] and_mask = '0, xor_mask = '0;
  logic [31:0] ctl_word, ctl_prev;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        fifo_wr;
  logic [7:0]  fifo_wdata;
  logic        fifo_rd = 1'b0;
  logic [CNT_W-1:0] fifo_free = 7'd32, free_thresh = 7'd4;
  logic        tx_valid = 1'b1;
  logic [7:0]  tx_byte = 8'h55;
  logic        tx_pop, tx_slot = 1'b0, tx_out_valid;
  logic [7:0]  tx_out_byte;
  logic        cts_n = 1'b0, dsr_n = 1'b0, dcd_n = 1'b0, ri = 1'b0;
  logic        dtr_n, rts_n, rx_evt;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_flow_ctrl u_serial_flow_ctrl (.*);

  typedef struct packed {
    logic [31:0] am;
    logic [31:0] xm;
    logic [31:0] exp_new;
    logic [31:0] exp_old;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{32'h0000_0000, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000},
    '{32'hFFFF_FFFF, 32'hA5A0_0000, 32'hA5A0_0001, 32'h0000_0001},
    '{32'hFFFF_FFFF, 32'h0000_F0F0, 32'hA5A0_F0F1, 32'hA5A0_0001},
    '{32'hFFFF_FFFF, 32'h001F_0000, 32'hA5A0_F0F1, 32'hA5A0_F0F1},
    '{32'h0000_000E, 32'h0000_0000, 32'h0000_0000, 32'hA5A0_F0F1},
    '{32'h0000_0000, 32'h0000_0006, 32'h0000_0006, 32'h0000_0000},
    '{32'hFFFF_FFF9, 32'h0000_0001, 32'h0000_0001, 32'h0000_0006}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] x);
    and_mask = a; xor_mask = x; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rx(input logic [7:0] b);
    rx_byte = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic slot();
    tx_slot = 1'b1;
    @(negedge clk);
    tx_slot = 1'b0;
  endtask

  task automatic rd();
    fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check("R12 word", ctl_word, 32'h0);
    check("R12 prev", ctl_prev, 32'h0);
    check("R12 pins", {28'h0, dtr_n, rts_n, rx_evt, tx_out_valid}, 32'h0);
    check("R12 strobes", {30'h0, fifo_wr, tx_pop}, 32'h0);

    // R1 R2 vector table
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i].am, VEC[i].xm);
      check("R1 R2 new word", ctl_word, VEC[i].exp_new);
      check("R1 old word", ctl_prev, VEC[i].exp_old);
    end

    // R4 R3 carrier lost, events
    dcd_n = 1'b1;
    @(negedge clk);
    check("R4 rise event", {31'h0, rx_evt}, 32'h1);
    check("R3 dcd mirror", {31'h0, ctl_word[18]}, 32'h1);
    @(negedge clk);
    check("R4 single pulse", {31'h0, rx_evt}, 32'h0);
    rx(8'h41);
    check("R4 drop char", {30'h0, fifo_wr, rx_evt}, 32'h1);
    dsr_n = 1'b1; ri = 1'b1;
    @(negedge clk);
    check("R3 dsr ring mirror", {30'h0, ctl_word[20], ctl_word[19]}, 32'h3);
    dcd_n = 1'b0; dsr_n = 1'b0; ri = 1'b0;
    @(negedge clk);
    check("R3 mirrors clear", {29'h0, ctl_word[20:18]}, 32'h0);

    // R4 carrier ignored
    wr(32'hFFFF_FFFF, 32'h2);
    dcd_n = 1'b1;
    @(negedge clk);
    check("R4 ignore rise", {31'h0, rx_evt}, 32'h0);
    rx(8'h41);
    check("R4 ignore store", {23'h0, fifo_wr, fifo_wdata}, {23'h0, 1'b1, 8'h41});
    dcd_n = 1'b0;
    @(negedge clk);
    wr(32'hFFFF_FFFD, 32'h0);

    // R5 R6 in-band pause
    rx(8'h13);
    check("R5 xoff consumed", {31'h0, fifo_wr}, 32'h0);
    check("R5 bit16 set", {31'h0, ctl_word[16]}, 32'h1);
    slot();
    check("R6 data held", {30'h0, tx_out_valid, tx_pop}, 32'h0);
    rx(8'h11);
    check("R5 xon consumed", {30'h0, fifo_wr, ctl_word[16]}, 32'h0);
    slot();
    check("R6 data resumes", {22'h0, tx_out_valid, tx_pop, tx_out_byte}, {22'h0, 2'b11, 8'h55});

    // R7 R8 nearly full in in-band mode
    fifo_free = 7'd3;
    rx(8'h42);
    check("R7 stored", {31'h0, fifo_wr}, 32'h1);
    check("R7 bit17 set", {30'h0, ctl_word[17], rts_n}, 32'h2);
    slot();
    check("R8 xoff first", {22'h0, tx_out_valid, tx_pop, tx_out_byte}, {22'h0, 2'b10, 8'h13});
    fifo_free = 7'd5;
    rd();
    check("R7 bit17 clear", {31'h0, ctl_word[17]}, 32'h0);
    slot();
    check("R8 xon sent", {22'h0, tx_out_valid, tx_pop, tx_out_byte}, {22'h0, 2'b10, 8'h11});
    slot();
    check("R8 sent once", {22'h0, tx_out_valid, tx_pop, tx_out_byte}, {22'h0, 2'b11, 8'h55});

    // R5 R7 hardware handshake mode
    wr(32'hFFFF_FFFE, 32'h0);
    rx(8'h13);
    check("R5 ctrl byte stored", {23'h0, fifo_wr, fifo_wdata}, {23'h0, 1'b1, 8'h13});
    fifo_free = 7'd3;
    rx(8'h43);
    check("R7 rts raised", {30'h0, ctl_word[17], rts_n}, 32'h1);
    slot();
    check("R8 no ctrl in hw mode", {23'h0, tx_out_valid, tx_out_byte}, {23'h0, 1'b1, 8'h55});
    fifo_free = 7'd5;
    rd();
    check("R7 rts lowered", {31'h0, rts_n}, 32'h0);
    fifo_free = 7'd32;

    // R9 CTS
    cts_n = 1'b1;
    slot();
    check("R9 cts blocks", {31'h0, tx_out_valid}, 32'h0);
    cts_n = 1'b0;

    // R10 DSR
    dsr_n = 1'b1;
    @(negedge clk);
    slot();
    check("R10 dsr blocks", {31'h0, tx_out_valid}, 32'h0);
    wr(32'hFFFF_FFFF, 32'h4);
    slot();
    check("R10 dsr ignored", {31'h0, tx_out_valid}, 32'h1);
    dsr_n = 1'b0;
    wr(32'hFFFF_FFFB, 32'h0);

    // R11 DTR
    wr(32'hFFFF_FFFF, 32'h8);
    check("R11 dtr_n high", {31'h0, dtr_n}, 32'h1);
    slot();
    check("R11 no tx", {31'h0, tx_out_valid}, 32'h0);
    rx(8'h44);
    check("R11 no rx", {31'h0, fifo_wr}, 32'h0);
    wr(32'hFFFF_FFF7, 32'h0);
    check("R11 dtr_n low", {31'h0, dtr_n}, 32'h0);

    // R5 R1 leaving in-band mode hides bit16
    wr(32'hFFFF_FFFF, 32'h1);
    rx(8'h13);
    check("R5 bit16 before", ctl_word, 32'h0001_0001);
    wr(32'hFFFF_FFFE, 32'h0);
    check("R5 bit16 hidden", ctl_word, 32'h0);
    check("R1 old with status", ctl_prev, 32'h0001_0001);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog got=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule